// File: doc/BRIEF.md
# Ring Setup Parameter Loader

This block brings a network controller's operating registers up from a parameter block held in system memory. The host writes the block's start address as two 16-bit halves, picks the logical entry width, and then sets an initialization command bit. The loader reads the block as a series of 32-bit words through a request/response master port. It unpacks each word into the mode word, the 48-bit station address, the 64-bit multicast filter, and the receive and transmit ring base addresses and size codes. When the last word has landed, it raises a completion flag.

The completion flag drives an interrupt output when interrupts are enabled. The transmitter and receiver enable outputs follow a start bit, but only once a fetch has completed, and each is gated by its own disable bit in the loaded mode word. The host may also write any of the target registers directly. A later fetch overwrites those values. Two channel flows exist, a request channel (address out) and a response channel (data in), both valid/ready. The loader offers a request only on alternate clock cycles, because its sequencer steps at half the clock rate. Between offers, valid drops and the address is held. The memory side may hold ready low for any number of cycles to stall either channel. A response is taken only when both valid and ready are high at a clock edge.

Top module: `ring_init_loader`

## Requirements
- R1: After reset every host-visible register reads 0 (including the width select, so 16-bit entries are the default), and `tx_enable`, `rx_enable`, `irq` and `mem_req_valid` are low.
- R2: The fetch reads consecutive 32-bit words starting at {base-high register (host address 2) bits 15:0, base-low register (host address 1) bits 15:0}. Word k is requested at start + 4*k, so every request address is word aligned.
- R3: With width select (host address 3, bit 0) at 0, exactly 6 words are read. Word 0 gives mode = [15:0] and station[15:0] = [31:16]. Word 1 gives station[47:16]. Words 2 and 3 give filter[31:0] and filter[63:32]. Word 4 gives receive base = {8'h00, [23:16], [15:0]} and receive size = [31:28]. Word 5 gives the transmit base and size in the same way.
- R4: With width select at 1, exactly 7 words are read. Word 0 gives mode = [15:0], receive size = [23:20] and transmit size = [31:28]. Word 1 gives station[31:0]. Word 2 [15:0] gives station[47:32]. Words 3 and 4 give the filter halves. Word 5 gives the full receive base and word 6 the full transmit base.
- R5: Control/status (address 0) bit 3 reads 1 once the last word is loaded, and bit 4 reads 1 while a fetch is pending or running. Writing a 1 to bit 3 clears the done flag.
- R6: `irq` is high exactly when the done flag is set and the interrupt-enable bit (control bit 2, rewritten by every control write) is 1.
- R7: `tx_enable` = start & fetched & ~mode[1] and `rx_enable` = start & fetched & ~mode[0]. Start is set by writing control bit 1 and cleared by writing control bit 4. "Fetched" is cleared when a fetch is accepted and set when it completes, so start may be set with the init bit or later. Control read bits 5 and 6 mirror the two enables.
- R8: Requests are offered only while busy and never on two consecutive cycles, and the request and response channels are never both active in one cycle. The fetch completes under any pattern of ready/valid stalls.
- R9: An init command written while a fetch is pending or running is ignored, so no extra words are read.
- R10: Host writes to the target registers (addresses 4 to 11) take effect and read back. A later fetch replaces them with the fetched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the request |
| mem_rsp_valid | input | 1 | Read data available |
| mem_rsp_ready | output | 1 | Loader takes the read data |
| mem_rsp_data | input | 32 | Read data word |
| tx_enable | output | 1 | Transmitter enable |
| rx_enable | output | 1 | Receiver enable |
| irq | output | 1 | Completion interrupt |

## Verification
The fetch is swept over both entry widths and four start addresses. One start address carries into bit 16 partway through the block, which separates a correct 32-bit address sum from one that only steps the low half. Each combination runs against three memory stall patterns: no stall, sparse ready with delayed data, and mostly-ready with short delays. These show whether words land in the right fields regardless of when the handshakes fall. Memory contents are a hash of the address, so a word taken from the wrong offset or unpacked with the wrong layout changes the read-back values. Directed cases cover a repeated init while busy, a direct host write later overwritten, a start issued after completion, and mode words that disable one section at a time.

// File: rtl/ril_pkg.sv
package ril_pkg;
  localparam int DW     = 32;
  localparam int HW     = 16;
  localparam int MODE_W = 16;
  localparam int STA_W  = 48;
  localparam int FLT_W  = 64;
  localparam int LEN_W  = 4;
  localparam int AW     = 4;
  localparam int NW16   = 6;
  localparam int NW32   = 7;
  localparam int IDX_W  = $clog2(NW32);
  localparam int STA_SL = STA_W / HW;
  localparam int FLT_SL = FLT_W / DW;

  localparam logic [AW-1:0] RA_CSR     = 4'd0;
  localparam logic [AW-1:0] RA_BASE_LO = 4'd1;
  localparam logic [AW-1:0] RA_BASE_HI = 4'd2;
  localparam logic [AW-1:0] RA_WIDTH   = 4'd3;
  localparam logic [AW-1:0] RA_MODE    = 4'd4;
  localparam logic [AW-1:0] RA_STA_LO  = 4'd5;
  localparam logic [AW-1:0] RA_STA_HI  = 4'd6;
  localparam logic [AW-1:0] RA_FLT_LO  = 4'd7;
  localparam logic [AW-1:0] RA_FLT_HI  = 4'd8;
  localparam logic [AW-1:0] RA_RXB     = 4'd9;
  localparam logic [AW-1:0] RA_TXB     = 4'd10;
  localparam logic [AW-1:0] RA_LENS    = 4'd11;

  localparam int CB_INIT  = 0;
  localparam int CB_START = 1;
  localparam int CB_IE    = 2;
  localparam int CB_DONE  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_BUSY  = 4;
  localparam int CB_TXON  = 5;
  localparam int CB_RXON  = 6;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [STA_W-1:0]  sta;
    logic [FLT_W-1:0]  flt;
    logic [DW-1:0]     rxb;
    logic [DW-1:0]     txb;
    logic [LEN_W-1:0]  rxl;
    logic [LEN_W-1:0]  txl;
  } cfg_t;

  typedef struct packed {
    logic              mode;
    logic [STA_SL-1:0] sta;
    logic [FLT_SL-1:0] flt;
    logic              rxb;
    logic              txb;
    logic              rxl;
    logic              txl;
  } cfg_en_t;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_t;
endpackage

// File: rtl/ril_unpack.sv
module ril_unpack
  import ril_pkg::*;
(
  input  logic             load,
  input  logic             wide,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    dat,
  output cfg_t             upd,
  output cfg_en_t          en
);
  logic [HW-1:0] lo, hi;
  assign lo = dat[HW-1:0];
  assign hi = dat[DW-1:HW];

  always_comb begin
    upd = '0;
    en  = '0;
    if (load) begin
      if (!wide) begin
        case (idx)
          3'd0: begin
            upd.mode = lo;        en.mode = 1'b1;
            upd.sta[15:0] = hi;   en.sta[0] = 1'b1;
          end
          3'd1: begin upd.sta[47:16] = dat; en.sta[2:1] = 2'b11; end
          3'd2: begin upd.flt[31:0]  = dat; en.flt[0] = 1'b1; end
          3'd3: begin upd.flt[63:32] = dat; en.flt[1] = 1'b1; end
          3'd4: begin
            upd.rxb = {8'h00, hi[7:0], lo}; en.rxb = 1'b1;
            upd.rxl = hi[15:12];            en.rxl = 1'b1;
          end
          3'd5: begin
            upd.txb = {8'h00, hi[7:0], lo}; en.txb = 1'b1;
            upd.txl = hi[15:12];            en.txl = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (idx)
          3'd0: begin
            upd.mode = lo;          en.mode = 1'b1;
            upd.rxl  = dat[23:20];  en.rxl  = 1'b1;
            upd.txl  = dat[31:28];  en.txl  = 1'b1;
          end
          3'd1: begin upd.sta[31:0]  = dat; en.sta[1:0] = 2'b11; end
          3'd2: begin upd.sta[47:32] = lo;  en.sta[2] = 1'b1; end
          3'd3: begin upd.flt[31:0]  = dat; en.flt[0] = 1'b1; end
          3'd4: begin upd.flt[63:32] = dat; en.flt[1] = 1'b1; end
          3'd5: begin upd.rxb = dat; en.rxb = 1'b1; end
          3'd6: begin upd.txb = dat; en.txb = 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ril_fetch_seq.sv
module ril_fetch_seq
  import ril_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic [DW-1:0]    base,
  input  logic             wide,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [DW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  output logic             load_en,
  output logic [IDX_W-1:0] idx,
  output logic             wide_q,
  output logic             busy,
  output logic             accept,
  output logic             done_pulse
);
  seq_st_t          st_q;
  logic             tick_q, pend_q;
  logic [DW-1:0]    base_q;
  logic [IDX_W-1:0] last;

  assign last          = wide_q ? IDX_W'(NW32 - 1) : IDX_W'(NW16 - 1);
  assign busy          = pend_q | (st_q != S_IDLE);
  assign accept        = init_req & ~busy;
  assign mem_req_valid = (st_q == S_REQ) & tick_q;
  assign mem_req_addr  = base_q + {{(DW-IDX_W-2){1'b0}}, idx, 2'b00};
  assign mem_rsp_ready = (st_q == S_WAIT) & tick_q;
  assign load_en       = mem_rsp_ready & mem_rsp_valid;
  assign done_pulse    = load_en & (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tick_q <= 1'b0;
      pend_q <= 1'b0;
      base_q <= '0;
      wide_q <= 1'b0;
      idx    <= '0;
    end else begin
      tick_q <= ~tick_q;
      if (accept) begin
        pend_q <= 1'b1;
        base_q <= base;
        wide_q <= wide;
      end
      case (st_q)
        S_IDLE: if (pend_q && tick_q) begin
          st_q   <= S_REQ;
          idx    <= '0;
          pend_q <= 1'b0;
        end
        S_REQ: if (mem_req_valid && mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (load_en) begin
          if (done_pulse) st_q <= S_IDLE;
          else begin
            idx  <= idx + 1'b1;
            st_q <= S_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ril_host_regs.sv
module ril_host_regs
  import ril_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  cfg_t          upd,
  input  cfg_en_t       en,
  input  logic          accept,
  input  logic          done_pulse,
  input  logic          busy,
  output logic          init_req,
  output logic [DW-1:0] base,
  output logic          wide,
  output logic          tx_en,
  output logic          rx_en,
  output logic          irq,
  output logic          done_q,
  output logic          ie_q
);
  logic             csr_we;
  logic             start_q, fetched_q;
  logic [HW-1:0]    blo_q, bhi_q;
  logic [MODE_W-1:0] mode_q;
  logic [HW-1:0]    sta_q [STA_SL];
  logic [DW-1:0]    flt_q [FLT_SL];
  logic [DW-1:0]    rxb_q, txb_q;
  logic [LEN_W-1:0] rxl_q, txl_q;

  assign csr_we   = we && (addr == RA_CSR);
  assign init_req = csr_we && wdata[CB_INIT];
  assign base     = {bhi_q, blo_q};
  assign tx_en    = start_q & fetched_q & ~mode_q[1];
  assign rx_en    = start_q & fetched_q & ~mode_q[0];
  assign irq      = done_q & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; fetched_q <= 1'b0; done_q <= 1'b0; ie_q <= 1'b0;
      blo_q <= '0; bhi_q <= '0; wide <= 1'b0;
      mode_q <= '0; rxb_q <= '0; txb_q <= '0; rxl_q <= '0; txl_q <= '0;
    end else begin
      if (csr_we) begin
        ie_q    <= wdata[CB_IE];
        start_q <= (start_q | wdata[CB_START]) & ~wdata[CB_STOP];
      end
      if (done_pulse) done_q <= 1'b1;
      else if (csr_we && wdata[CB_DONE]) done_q <= 1'b0;
      if (accept) fetched_q <= 1'b0;
      else if (done_pulse) fetched_q <= 1'b1;
      if (we && addr == RA_BASE_LO) blo_q <= wdata[HW-1:0];
      if (we && addr == RA_BASE_HI) bhi_q <= wdata[HW-1:0];
      if (we && addr == RA_WIDTH)   wide  <= wdata[0];
      if (en.mode) mode_q <= upd.mode;
      else if (we && addr == RA_MODE) mode_q <= wdata[MODE_W-1:0];
      if (en.rxb) rxb_q <= upd.rxb;
      else if (we && addr == RA_RXB) rxb_q <= wdata;
      if (en.txb) txb_q <= upd.txb;
      else if (we && addr == RA_TXB) txb_q <= wdata;
      if (en.rxl) rxl_q <= upd.rxl;
      else if (we && addr == RA_LENS) rxl_q <= wdata[LEN_W-1:0];
      if (en.txl) txl_q <= upd.txl;
      else if (we && addr == RA_LENS) txl_q <= wdata[2*LEN_W-1:LEN_W];
    end
  end

  for (genvar i = 0; i < STA_SL; i++) begin : g_sta
    logic hw_sel;
    assign hw_sel = we && (addr == ((i < 2) ? RA_STA_LO : RA_STA_HI));
    always_ff @(posedge clk) begin
      if (!rst_n) sta_q[i] <= '0;
      else if (en.sta[i]) sta_q[i] <= upd.sta[i*HW +: HW];
      else if (hw_sel) sta_q[i] <= wdata[(i%2)*HW +: HW];
    end
  end

  for (genvar j = 0; j < FLT_SL; j++) begin : g_flt
    logic hw_sel;
    assign hw_sel = we && (addr == ((j == 0) ? RA_FLT_LO : RA_FLT_HI));
    always_ff @(posedge clk) begin
      if (!rst_n) flt_q[j] <= '0;
      else if (en.flt[j]) flt_q[j] <= upd.flt[j*DW +: DW];
      else if (hw_sel) flt_q[j] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CSR: begin
        rdata[CB_START] = start_q;
        rdata[CB_IE]    = ie_q;
        rdata[CB_DONE]  = done_q;
        rdata[CB_BUSY]  = busy;
        rdata[CB_TXON]  = tx_en;
        rdata[CB_RXON]  = rx_en;
      end
      RA_BASE_LO: rdata[HW-1:0] = blo_q;
      RA_BASE_HI: rdata[HW-1:0] = bhi_q;
      RA_WIDTH:   rdata[0] = wide;
      RA_MODE:    rdata[MODE_W-1:0] = mode_q;
      RA_STA_LO:  rdata = {sta_q[1], sta_q[0]};
      RA_STA_HI:  rdata[HW-1:0] = sta_q[2];
      RA_FLT_LO:  rdata = flt_q[0];
      RA_FLT_HI:  rdata = flt_q[1];
      RA_RXB:     rdata = rxb_q;
      RA_TXB:     rdata = txb_q;
      RA_LENS:    rdata[2*LEN_W-1:0] = {txl_q, rxl_q};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ring_init_loader.sv
module ring_init_loader
  import ril_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [3:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [31:0]   mem_rsp_data,
  output logic          tx_enable,
  output logic          rx_enable,
  output logic          irq
);
  cfg_t             upd_w;
  cfg_en_t          en_w;
  logic             load_w, wide_q_w, busy_w, accept_w, done_p_w;
  logic             init_w, wide_w, done_w, ie_w;
  logic [IDX_W-1:0] idx_w;
  logic [DW-1:0]    base_w;

  ril_fetch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_w), .base(base_w), .wide(wide_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .load_en(load_w), .idx(idx_w),
    .wide_q(wide_q_w), .busy(busy_w), .accept(accept_w), .done_pulse(done_p_w)
  );

  ril_unpack u_unpack (
    .load(load_w), .wide(wide_q_w), .idx(idx_w), .dat(mem_rsp_data),
    .upd(upd_w), .en(en_w)
  );

  ril_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .upd(upd_w), .en(en_w),
    .accept(accept_w), .done_pulse(done_p_w), .busy(busy_w),
    .init_req(init_w), .base(base_w), .wide(wide_w), .tx_en(tx_enable),
    .rx_en(rx_enable), .irq(irq), .done_q(done_w), .ie_q(ie_w)
  );
endmodule

// File: rtl/ring_init_loader_chk.sv
module ring_init_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_ready,
  input logic        tx_enable,
  input logic        rx_enable,
  input logic        irq,
  input logic        busy,
  input logic        done,
  input logic        ie
);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  a_r8_alternate_offer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
  a_r8_offer_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!tx_enable && !rx_enable));
  a_r5_done_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && done));
endmodule

bind ring_init_loader ring_init_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_rsp_ready(mem_rsp_ready),
  .tx_enable(tx_enable), .rx_enable(rx_enable), .irq(irq),
  .busy(busy_w), .done(done_w), .ie(ie_w)
);

// File: tb/ring_init_loader_tb_top.sv
module ring_init_loader_tb_top;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tx_enable, rx_enable, irq;

  int n_chk = 0, n_err = 0, n_req = 0, n_consec = 0, stall_mode = 0, mcyc = 0;
  logic [31:0] alog [16];
  logic [15:0] exp_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_init_loader dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .irq(irq)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h6C8E_9CF5 ^ {a[15:0], a[31:16]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // memory model: decides each handshake half a cycle ahead of the edge
  initial begin
    logic        pend = 1'b0;
    logic        prev_v = 1'b0;
    int          wait_n = 0;
    logic [31:0] rdat = '0;
    forever begin
      @(negedge clk);
      mcyc++;
      if (mem_req_valid && prev_v) n_consec++;
      prev_v = mem_req_valid;
      case (stall_mode)
        0: mem_req_ready = 1'b1;
        1: mem_req_ready = (mcyc % 3) == 0;
        default: mem_req_ready = (mcyc % 4) != 3;
      endcase
      if (pend) begin
        if (wait_n > 0) begin
          wait_n--;
          mem_rsp_valid = 1'b0;
        end else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rdat;
          if (mem_rsp_ready) pend = 1'b0;
        end
      end else begin
        mem_rsp_valid = 1'b0;
        if (mem_req_valid && mem_req_ready) begin
          if (n_req < 16) alog[n_req] = mem_req_addr;
          n_req++;
          pend   = 1'b1;
          rdat   = mw(mem_req_addr);
          wait_n = stall_mode;
        end
      end
    end
  end

  task automatic run_fetch(input bit w, input logic [31:0] b, input int s,
                           input bit st, input bit ie, input bit dup);
    logic [31:0] d [7];
    logic [31:0] v;
    logic [15:0] mode;
    logic [47:0] sta;
    logic [63:0] flt;
    logic [31:0] rxb, txb;
    logic [3:0]  rxl, txl;
    int nw;
    bit seen;
    nw = w ? 7 : 6;
    for (int k = 0; k < 7; k++) d[k] = mw(b + 32'(4 * k));
    mode = d[0][15:0];
    if (!w) begin
      sta = {d[1], d[0][31:16]}; flt = {d[3], d[2]};
      rxb = {8'h00, d[4][23:16], d[4][15:0]}; rxl = d[4][31:28];
      txb = {8'h00, d[5][23:16], d[5][15:0]}; txl = d[5][31:28];
    end else begin
      sta = {d[2][15:0], d[1]}; flt = {d[4], d[3]};
      rxb = d[5]; txb = d[6]; rxl = d[0][23:20]; txl = d[0][31:28];
    end
    exp_mode = mode;
    stall_mode = s; n_req = 0; n_consec = 0;
    wr(4'd1, {16'h0, b[15:0]});
    wr(4'd2, {16'h0, b[31:16]});
    wr(4'd3, {31'h0, w});
    wr(4'd0, {27'h0, !st, 1'b0, ie, st, 1'b1});
    chk("R7 enables low during fetch", {30'h0, tx_enable, rx_enable}, 32'h0);
    rd(4'd0, v);
    chk("R5 busy while fetching", {31'h0, v[4]}, 32'h1);
    if (dup) wr(4'd0, {27'h0, 1'b0, 1'b0, ie, st, 1'b1});
    seen = 1'b0;
    for (int t = 0; t < 3000 && !seen; t++) begin
      @(negedge clk);
      rd(4'd0, v);
      seen = v[3];
    end
    chk(dup ? "R9 word count with repeated init" : (w ? "R4 word count" : "R3 word count"),
        32'(n_req), 32'(nw));
    for (int k = 0; k < nw && k < 16; k++)
      chk("R2 request address", alog[k], b + 32'(4 * k));
    chk("R8 no back-to-back offers", 32'(n_consec), 32'h0);
    rd(4'd0, v);
    chk("R5 done set, busy clear", {30'h0, v[3], v[4]}, 32'h2);
    chk("R6 irq at completion", {31'h0, irq}, {31'h0, ie});
    chk("R7 tx enable", {31'h0, tx_enable}, {31'h0, st & ~mode[1]});
    chk("R7 rx enable", {31'h0, rx_enable}, {31'h0, st & ~mode[0]});
    rd(4'd4, v);  chk(w ? "R4 mode" : "R3 mode", v, {16'h0, mode});
    rd(4'd5, v);  chk(w ? "R4 station low" : "R10 R3 station low", v, sta[31:0]);
    rd(4'd6, v);  chk(w ? "R4 station high" : "R3 station high", v, {16'h0, sta[47:32]});
    rd(4'd7, v);  chk(w ? "R4 filter low" : "R3 filter low", v, flt[31:0]);
    rd(4'd8, v);  chk(w ? "R4 filter high" : "R3 filter high", v, flt[63:32]);
    rd(4'd9, v);  chk(w ? "R4 rx base" : "R3 rx base", v, rxb);
    rd(4'd10, v); chk(w ? "R4 tx base" : "R3 tx base", v, txb);
    rd(4'd11, v); chk(w ? "R4 sizes" : "R3 sizes", v, {24'h0, txl, rxl});
    wr(4'd0, {28'h0, 1'b1, ie, st, 1'b0});
    rd(4'd0, v);
    chk("R5 done cleared by write-one", {31'h0, v[3]}, 32'h0);
    chk("R6 irq drops with done", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'h1234_5670;
    bases[2] = 32'h0001_FFF0; bases[3] = 32'hABCD_0008;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 outputs after reset", {28'h0, tx_enable, rx_enable, irq, mem_req_valid}, 32'h0);

    // R10: direct host writes read back
    wr(4'd5, 32'hDEAD_BEEF);
    rd(4'd5, v); chk("R10 direct station write", v, 32'hDEAD_BEEF);
    wr(4'd11, 32'h0000_00A5);
    rd(4'd11, v); chk("R10 direct size write", v, 32'h0000_00A5);

    // sweep: width x base x stall pattern
    for (int w = 0; w < 2; w++)
      for (int bi = 0; bi < 4; bi++)
        for (int s = 0; s < 3; s++)
          run_fetch(w[0], bases[bi], s, bi[0], s[0], (bi == 2));

    // R7: start after completion, then mode disable bits via direct write
    run_fetch(1'b0, 32'h0000_4000, 0, 1'b0, 1'b0, 1'b0);
    wr(4'd0, 32'h0000_0002);
    chk("R7 tx after late start", {31'h0, tx_enable}, {31'h0, ~exp_mode[1]});
    chk("R7 rx after late start", {31'h0, rx_enable}, {31'h0, ~exp_mode[0]});
    wr(4'd4, 32'h0000_0002);
    chk("R7 tx disabled by mode bit 1", {30'h0, tx_enable, rx_enable}, 32'h1);
    wr(4'd4, 32'h0000_0001);
    chk("R7 rx disabled by mode bit 0", {30'h0, tx_enable, rx_enable}, 32'h2);
    rd(4'd0, v);
    chk("R7 status mirrors enables", {30'h0, v[6], v[5]}, 32'h1);
    wr(4'd0, 32'h0000_0010);
    chk("R7 stop clears enables", {30'h0, tx_enable, rx_enable}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule